// File: doc/BRIEF.md
# Remote DMA Data Port Engine

This block sits between a host data port and the packet storage of a network adapter. In the transmit direction the host writes a frame through the data port. Each byte lands in an internal staging buffer at a write pointer, and the pointer advances by one. When the pointer reaches the programmed remote byte count, the engine pulses a remote-DMA-complete event and a request to clear the transmit-busy command bit. It then streams the staged bytes out on a valid/ready byte interface, raising a last flag on the final byte. Once that byte is accepted it pulses a transmit-OK event. A write to the command register returns the write pointer to zero.

In the receive direction each host read fetches bytes from the external packet memory, starting at the remote start address. The address advances after every byte fetched. The data port accepts byte, 16-bit and 32-bit accesses. A wide access is split into byte operations taken in little-endian order: writes consume the data from the least significant byte upward, and reads assemble the returned bytes the same way.

A control state machine owns the host side. Its states are IDLE, WRITE_BYTES, READ_ADDR, READ_DATA and SEND. The transitions are:
- IDLE to WRITE_BYTES on an accepted write request.
- IDLE to READ_ADDR on an accepted read request.
- WRITE_BYTES to SEND when the count is reached.
- WRITE_BYTES to IDLE after the last byte lane.
- READ_ADDR to READ_DATA always.
- READ_DATA back to READ_ADDR for the next lane, or to IDLE after the last lane.
- SEND to IDLE once the stream reports its final byte accepted.

A stream state machine has the states TX_IDLE, TX_FETCH and TX_SHOW. It moves TX_IDLE to TX_FETCH on start and TX_FETCH to TX_SHOW always. From TX_SHOW it returns to TX_FETCH after a non-final byte is accepted, or to TX_IDLE after the final byte is accepted.

Top module: `rdma_port_engine`

## Requirements
- R1: After reset, hp_busy, hp_rvalid, tx_valid, rdc_evt, txbusy_clr and txok_evt are all 0.
- R2: When the number of bytes written since the last pointer reset reaches byte_count, exactly byte_count bytes are emitted on the stream, in write order, with tx_last high on the final byte only.
- R3: hp_size encodes 0 = byte, 1 = 16-bit, 2 or 3 = 32-bit. A 16-bit write stores hp_wdata[7:0] then hp_wdata[15:8]. A 32-bit write stores its four bytes from bits [7:0] up to bits [31:24].
- R4: A count match produces exactly one rdc_evt pulse and one txbusy_clr pulse, both before the first frame byte is valid. Exactly one txok_evt pulse follows the acceptance of the final byte.
- R5: A cmd_wr pulse resets the write pointer to zero, so bytes written before it never appear in a later frame.
- R6: From a count match until txok_evt the block holds hp_busy high and accepts no host request. A read requested in that window issues no packet memory fetch and leaves the read address unchanged.
- R7: Byte lanes of a wide write that remain after the count is reached are discarded.
- R8: A byte read returns pm memory at the current read address in hp_rdata[7:0], with the upper bits zero. The address then increments, so consecutive reads walk memory.
- R9: A 16-bit read returns the bytes at addresses A and A+1 in bits [7:0] and [15:8], with bits [31:16] zero. A 32-bit read returns A..A+3 from the low byte upward. The address advances by 2 or 4.
- R10: A rsar_load pulse sets the read address to rsar_value.
- R11: The staging buffer holds DEPTH bytes. Bytes written when the pointer is at DEPTH are dropped and do not advance it. A byte_count above DEPTH, or equal to 0, never starts a frame. A byte_count of exactly DEPTH does start one.
- R12: While tx_valid is high and tx_ready is low, tx_valid, tx_data and tx_last stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command register write strobe; resets the write pointer |
| byte_count | input | CNT_W | Programmed remote byte count |
| rsar_load | input | 1 | Load strobe for the read start address |
| rsar_value | input | ADDR_W | Read start address value |
| hp_req | input | 1 | Host data port access request |
| hp_write | input | 1 | 1 = write, 0 = read |
| hp_size | input | 2 | Access size: 0 byte, 1 16-bit, 2/3 32-bit |
| hp_wdata | input | 32 | Host write data |
| hp_busy | output | 1 | Engine busy; requests are taken only when low |
| hp_rvalid | output | 1 | One-cycle pulse: hp_rdata holds a completed read |
| hp_rdata | output | 32 | Assembled read data |
| pm_rd | output | 1 | Packet memory fetch strobe |
| pm_addr | output | ADDR_W | Packet memory byte address |
| pm_rdata | input | 8 | Packet memory data, one cycle after pm_rd |
| tx_valid | output | 1 | Frame byte valid |
| tx_ready | input | 1 | Frame sink ready |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of the frame |
| rdc_evt | output | 1 | Remote-DMA-complete pulse |
| txbusy_clr | output | 1 | Pulse requesting command bit 2 be cleared |
| txok_evt | output | 1 | Transmit-OK pulse |

## Verification
The write path is driven with byte, 16-bit and 32-bit writes, so the frame byte order tells apart correct lane splitting from reversed or skipped lanes. A 32-bit write with a count of 3 shows whether surplus lanes leak past the count. A pointer reset between writes shows whether stale bytes survive into a frame. Counts of 0, exactly DEPTH and DEPTH plus one separate a correct capacity guard from an off-by-one. The stream sink runs always-ready, alternating and pseudo-random, which separates a correct hold under backpressure from a design that advances early. Reads of every size from a loaded start address, including one requested while a frame is stalled, show the byte order, the increment step and that a busy engine leaves the address alone.

// File: rtl/rdma_pkg.sv
package rdma_pkg;

    typedef enum logic [2:0] {
        C_IDLE,
        C_WR,
        C_RD_ADDR,
        C_RD_DATA,
        C_SEND
    } ctrl_state_e;

    typedef enum logic [1:0] {
        T_IDLE,
        T_FETCH,
        T_SHOW
    } tx_state_e;

    // index of the final byte lane for an access size
    function automatic logic [1:0] final_lane(input logic [1:0] sz);
        unique case (sz)
            2'd0:    return 2'd0;
            2'd1:    return 2'd1;
            default: return 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/rdma_stage_buf.sv
module rdma_stage_buf #(
    parameter int DEPTH = 1536,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (re) begin
            rdata <= mem[raddr];
        end
    end

    // R11: storage is never addressed past its capacity
    p_wr_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> ({1'b0, waddr} < (AW+1)'(DEPTH)));

endmodule

// File: rtl/rdma_tx_stream.sv
module rdma_tx_stream
    import rdma_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int AW    = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] len,
    output logic             rd_en,
    output logic [AW-1:0]    rd_addr,
    input  logic [7:0]       rd_data,
    output logic             tx_valid,
    input  logic             tx_ready,
    output logic [7:0]       tx_data,
    output logic             tx_last,
    output logic             done
);

    tx_state_e        state_q, state_d;
    logic [CNT_W-1:0] idx_q;
    logic [CNT_W-1:0] len_q;
    logic             at_end;

    assign at_end = (idx_q == len_q - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= T_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            T_IDLE:  if (start) state_d = T_FETCH;
            T_FETCH: state_d = T_SHOW;
            T_SHOW: begin
                if (tx_ready) begin
                    state_d = at_end ? T_IDLE : T_FETCH;
                end
            end
            default: state_d = T_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            len_q <= '0;
        end else begin
            if (state_q == T_IDLE && start) begin
                idx_q <= '0;
                len_q <= len;
            end else if (state_q == T_SHOW && tx_ready && !at_end) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    always_comb begin
        rd_en    = (state_q == T_FETCH);
        rd_addr  = idx_q[AW-1:0];
        tx_valid = (state_q == T_SHOW);
        tx_data  = rd_data;
        tx_last  = tx_valid && at_end;
        done     = tx_valid && tx_ready && at_end;
    end

    // R12: a stalled byte is held unchanged
    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    // R2: nothing follows the final byte of a frame
    p_end_of_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !tx_valid);

endmodule

// File: rtl/rdma_ctrl.sv
module rdma_ctrl
    import rdma_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 1536,
    parameter int AW     = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [CNT_W-1:0]  byte_count,
    input  logic              rsar_load,
    input  logic [ADDR_W-1:0] rsar_value,
    input  logic              hp_req,
    input  logic              hp_write,
    input  logic [1:0]        hp_size,
    input  logic [31:0]       hp_wdata,
    output logic              hp_busy,
    output logic              hp_rvalid,
    output logic [31:0]       hp_rdata,
    output logic              pm_rd,
    output logic [ADDR_W-1:0] pm_addr,
    input  logic [7:0]        pm_rdata,
    output logic              st_we,
    output logic [AW-1:0]     st_waddr,
    output logic [7:0]        st_wdata,
    output logic              tx_start,
    output logic [CNT_W-1:0]  tx_len,
    input  logic              tx_done,
    input  logic              tx_valid_mon,
    output logic              rdc_evt,
    output logic              txbusy_clr,
    output logic              txok_evt
);

    ctrl_state_e       state_q, state_d;
    logic [1:0]        lane_q, last_q;
    logic [31:0]       wdata_q;
    logic [31:0]       acc_q;
    logic [CNT_W-1:0]  wptr_q;
    logic [CNT_W-1:0]  wptr_inc;
    logic [ADDR_W-1:0] raddr_q;
    logic              room;
    logic              hit;
    logic              accept;
    logic [31:0]       rdata_q;
    logic              rvalid_q, rdc_q, clr_q, txok_q;

    assign room     = ({1'b0, wptr_q} < (CNT_W+1)'(DEPTH));
    assign wptr_inc = wptr_q + 1'b1;
    assign accept   = hp_req && (state_q == C_IDLE);
    assign hit      = (state_q == C_WR) && room && (wptr_inc == byte_count);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= C_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            C_IDLE: begin
                if (accept) state_d = hp_write ? C_WR : C_RD_ADDR;
            end
            C_WR: begin
                if (hit)                  state_d = C_SEND;
                else if (lane_q == last_q) state_d = C_IDLE;
            end
            C_RD_ADDR: state_d = C_RD_DATA;
            C_RD_DATA: state_d = (lane_q == last_q) ? C_IDLE : C_RD_ADDR;
            C_SEND:    if (tx_done) state_d = C_IDLE;
            default:   state_d = C_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane_q   <= '0;
            last_q   <= '0;
            wdata_q  <= '0;
            acc_q    <= '0;
            wptr_q   <= '0;
            raddr_q  <= '0;
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
            rdc_q    <= 1'b0;
            clr_q    <= 1'b0;
            txok_q   <= 1'b0;
        end else begin
            if (accept) begin
                lane_q  <= '0;
                last_q  <= final_lane(hp_size);
                wdata_q <= hp_wdata;
                acc_q   <= '0;
            end else if (state_q == C_WR) begin
                lane_q <= lane_q + 1'b1;
            end else if (state_q == C_RD_DATA) begin
                acc_q[{lane_q, 3'b000} +: 8] <= pm_rdata;
                lane_q <= lane_q + 1'b1;
            end

            if (cmd_wr) begin
                wptr_q <= '0;
            end else if (state_q == C_WR && room) begin
                wptr_q <= wptr_inc;
            end

            if (rsar_load) begin
                raddr_q <= rsar_value;
            end else if (state_q == C_RD_ADDR) begin
                raddr_q <= raddr_q + 1'b1;
            end

            rvalid_q <= (state_q == C_RD_DATA) && (lane_q == last_q);
            if ((state_q == C_RD_DATA) && (lane_q == last_q)) begin
                rdata_q <= acc_q | ({24'b0, pm_rdata} << {lane_q, 3'b000});
            end

            rdc_q  <= hit;
            clr_q  <= hit;
            txok_q <= (state_q == C_SEND) && tx_done;
        end
    end

    // outputs
    always_comb begin
        hp_busy    = (state_q != C_IDLE);
        hp_rvalid  = rvalid_q;
        hp_rdata   = rdata_q;
        pm_rd      = (state_q == C_RD_ADDR);
        pm_addr    = raddr_q;
        st_we      = (state_q == C_WR) && room;
        st_waddr   = wptr_q[AW-1:0];
        st_wdata   = wdata_q[{lane_q, 3'b000} +: 8];
        tx_start   = hit;
        tx_len     = byte_count;
        rdc_evt    = rdc_q;
        txbusy_clr = clr_q;
        txok_evt   = txok_q;
    end

    // R6: the stream only runs while the host side is parked in SEND
    p_tx_in_send_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid_mon |-> (state_q == C_SEND));

    // R4: completion and transmit-OK never coincide
    p_evt_apart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(rdc_q && txok_q));

    // R5: a command write empties the pointer
    p_cmd_clears_ptr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> (wptr_q == '0));

    // R8: read completion is a single-cycle pulse
    p_rvalid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_q |=> !rvalid_q);

endmodule

// File: rtl/rdma_port_engine.sv
module rdma_port_engine #(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 1536
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [CNT_W-1:0]  byte_count,
    input  logic              rsar_load,
    input  logic [ADDR_W-1:0] rsar_value,
    input  logic              hp_req,
    input  logic              hp_write,
    input  logic [1:0]        hp_size,
    input  logic [31:0]       hp_wdata,
    output logic              hp_busy,
    output logic              hp_rvalid,
    output logic [31:0]       hp_rdata,
    output logic              pm_rd,
    output logic [ADDR_W-1:0] pm_addr,
    input  logic [7:0]        pm_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    output logic              rdc_evt,
    output logic              txbusy_clr,
    output logic              txok_evt
);

    localparam int AW = $clog2(DEPTH);

    logic             st_we;
    logic [AW-1:0]    st_waddr;
    logic [7:0]       st_wdata;
    logic             st_re;
    logic [AW-1:0]    st_raddr;
    logic [7:0]       st_rdata;
    logic             tx_start;
    logic [CNT_W-1:0] tx_len;
    logic             tx_done;

    rdma_ctrl #(
        .CNT_W (CNT_W),
        .ADDR_W(ADDR_W),
        .DEPTH (DEPTH),
        .AW    (AW)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_wr      (cmd_wr),
        .byte_count  (byte_count),
        .rsar_load   (rsar_load),
        .rsar_value  (rsar_value),
        .hp_req      (hp_req),
        .hp_write    (hp_write),
        .hp_size     (hp_size),
        .hp_wdata    (hp_wdata),
        .hp_busy     (hp_busy),
        .hp_rvalid   (hp_rvalid),
        .hp_rdata    (hp_rdata),
        .pm_rd       (pm_rd),
        .pm_addr     (pm_addr),
        .pm_rdata    (pm_rdata),
        .st_we       (st_we),
        .st_waddr    (st_waddr),
        .st_wdata    (st_wdata),
        .tx_start    (tx_start),
        .tx_len      (tx_len),
        .tx_done     (tx_done),
        .tx_valid_mon(tx_valid),
        .rdc_evt     (rdc_evt),
        .txbusy_clr  (txbusy_clr),
        .txok_evt    (txok_evt)
    );

    rdma_stage_buf #(
        .DEPTH(DEPTH),
        .AW   (AW)
    ) u_buf (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (st_we),
        .waddr(st_waddr),
        .wdata(st_wdata),
        .re   (st_re),
        .raddr(st_raddr),
        .rdata(st_rdata)
    );

    rdma_tx_stream #(
        .CNT_W(CNT_W),
        .AW   (AW)
    ) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tx_start),
        .len     (tx_len),
        .rd_en   (st_re),
        .rd_addr (st_raddr),
        .rd_data (st_rdata),
        .tx_valid(tx_valid),
        .tx_ready(tx_ready),
        .tx_data (tx_data),
        .tx_last (tx_last),
        .done    (tx_done)
    );

endmodule

// File: tb/sim_rdma_port_engine.sv
module sim_rdma_port_engine;

    localparam int DEPTH = 1536;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [15:0] byte_count = '0;
    logic        rsar_load = 1'b0;
    logic [15:0] rsar_value = '0;
    logic        hp_req = 1'b0;
    logic        hp_write = 1'b0;
    logic [1:0]  hp_size = '0;
    logic [31:0] hp_wdata = '0;
    logic        hp_busy, hp_rvalid;
    logic [31:0] hp_rdata;
    logic        pm_rd;
    logic [15:0] pm_addr;
    logic [7:0]  pm_rdata = '0;
    logic        tx_valid, tx_last;
    logic        tx_ready = 1'b1;
    logic [7:0]  tx_data;
    logic        rdc_evt, txbusy_clr, txok_evt;

    always #4 clk = ~clk;

    rdma_port_engine u0 (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .byte_count(byte_count),
        .rsar_load(rsar_load), .rsar_value(rsar_value),
        .hp_req(hp_req), .hp_write(hp_write), .hp_size(hp_size), .hp_wdata(hp_wdata),
        .hp_busy(hp_busy), .hp_rvalid(hp_rvalid), .hp_rdata(hp_rdata),
        .pm_rd(pm_rd), .pm_addr(pm_addr), .pm_rdata(pm_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
        .rdc_evt(rdc_evt), .txbusy_clr(txbusy_clr), .txok_evt(txok_evt)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return 8'((a[7:0] * 8'd7) ^ a[15:8]) + 8'h5d;
    endfunction

    // packet memory: one cycle read latency
    always @(posedge clk) begin
        if (pm_rd) pm_rdata <= mem_byte(pm_addr);
    end

    // reference model state
    int         m_wptr = 0;
    int         m_count = 0;
    logic [7:0] m_stage [0:DEPTH+7];
    logic [7:0] exp_q [$];
    int         m_raddr = 0;
    int         rdc_cnt = 0, clr_cnt = 0, txok_cnt = 0, byte_cnt = 0;

    // sink readiness patterns
    int          rdy_mode = 0;
    logic [15:0] lfsr = 16'hace1;
    initial begin
        forever begin
            @(posedge clk);
            #1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (rdy_mode)
                0: tx_ready = 1'b1;
                1: tx_ready = ~tx_ready;
                2: tx_ready = lfsr[0];
                default: tx_ready = 1'b0;
            endcase
        end
    end

    // per-clock comparison against the model
    bit         prev_stall = 0;
    logic [7:0] prev_data = '0;
    logic       prev_last = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall)
                chk(tx_valid && tx_data == prev_data && tx_last == prev_last, "R12 hold",
                    {tx_valid, tx_last, tx_data}, {1'b1, prev_last, prev_data});
            if (tx_valid && !hp_busy)
                chk(1'b0, "R6 stream while idle", 32'(hp_busy), 32'd1);
            if (rdc_evt) begin
                rdc_cnt++;
                chk(!tx_valid && exp_q.size() > 0, "R4 rdc before frame", 32'(tx_valid), 32'd0);
            end
            if (txbusy_clr) clr_cnt++;
            if (txok_evt) begin
                txok_cnt++;
                chk(exp_q.size() == 0, "R4 txok after last", 32'(exp_q.size()), 32'd0);
            end
            if (tx_valid && tx_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2 unexpected byte", 32'(tx_data), 32'd0);
                end else begin
                    chk(tx_data == exp_q[0] && tx_last == (exp_q.size() == 1), "R2 frame byte",
                        {tx_last, tx_data}, {(exp_q.size() == 1), exp_q[0]});
                    void'(exp_q.pop_front());
                    byte_cnt++;
                end
            end
            prev_stall = tx_valid && !tx_ready;
            prev_data  = tx_data;
            prev_last  = tx_last;
        end
    end

    task automatic model_write(input logic [1:0] sz, input logic [31:0] d);
        int  n;
        bit  fired;
        n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        fired = 0;
        for (int i = 0; i < n && !fired; i++) begin
            if (m_wptr < DEPTH) begin
                m_stage[m_wptr] = d[8*i +: 8];
                m_wptr++;
                if (m_wptr == m_count) begin
                    for (int k = 0; k < m_count; k++) exp_q.push_back(m_stage[k]);
                    fired = 1;
                end
            end
        end
    endtask

    task automatic issue(input bit wr, input logic [1:0] sz, input logic [31:0] d);
        while (hp_busy) @(negedge clk);
        hp_req = 1'b1; hp_write = wr; hp_size = sz; hp_wdata = d;
        @(negedge clk);
        hp_req = 1'b0;
    endtask

    task automatic host_write(input logic [1:0] sz, input logic [31:0] d);
        issue(1'b1, sz, d);
        model_write(sz, d);
        while (hp_busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic host_read(input logic [1:0] sz, input string tag);
        int          n;
        logic [31:0] e;
        int          guard;
        n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        e = '0;
        for (int i = 0; i < n; i++) e[8*i +: 8] = mem_byte(16'(m_raddr + i));
        m_raddr = (m_raddr + n) & 16'hffff;
        issue(1'b0, sz, 32'd0);
        guard = 0;
        while (!hp_rvalid && guard < 50) begin
            @(negedge clk);
            guard++;
        end
        chk(hp_rvalid && hp_rdata == e, tag, hp_rdata, e);
        @(negedge clk);
    endtask

    task automatic do_cmd();
        @(negedge clk);
        cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
        m_wptr = 0;
    endtask

    task automatic set_count(input int v);
        byte_count = 16'(v);
        m_count = v;
    endtask

    task automatic load_addr(input logic [15:0] a);
        @(negedge clk);
        rsar_load = 1'b1; rsar_value = a;
        @(negedge clk);
        rsar_load = 1'b0;
        m_raddr = a;
    endtask

    task automatic frame_done(input int r0, input int b0, input int len, input string tag);
        chk(rdc_cnt == r0 + 1 && clr_cnt == r0 + 1, {tag, " R4 one rdc/clr"}, 32'(rdc_cnt - r0), 32'd1);
        chk(txok_cnt == r0 + 1, {tag, " R4 one txok"}, 32'(txok_cnt - r0), 32'd1);
        chk(byte_cnt - b0 == len, {tag, " R2 frame length"}, 32'(byte_cnt - b0), 32'(len));
    endtask

    initial begin
        int r0, b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(!hp_busy && !hp_rvalid && !tx_valid && !rdc_evt && !txbusy_clr && !txok_evt,
            "R1 reset state", {hp_busy, hp_rvalid, tx_valid, rdc_evt, txbusy_clr, txok_evt}, 32'd0);

        // R2: byte writes, always ready
        r0 = rdc_cnt; b0 = byte_cnt;
        do_cmd(); set_count(5);
        for (int i = 0; i < 5; i++) host_write(2'd0, 32'h10 + i);
        frame_done(r0, b0, 5, "R2 bytes");

        // R3: 16-bit writes, alternating ready
        rdy_mode = 1;
        r0 = rdc_cnt; b0 = byte_cnt;
        do_cmd(); set_count(6);
        host_write(2'd1, 32'h0000_a1b2);
        host_write(2'd1, 32'h0000_c3d4);
        host_write(2'd1, 32'h0000_e5f6);
        frame_done(r0, b0, 6, "R3 half");

        // R3: 32-bit writes (size 2 and 3), random ready
        rdy_mode = 2;
        r0 = rdc_cnt; b0 = byte_cnt;
        do_cmd(); set_count(8);
        host_write(2'd2, 32'h4433_2211);
        host_write(2'd3, 32'h8877_6655);
        frame_done(r0, b0, 8, "R3 word");

        // R7: surplus lanes after count discarded
        r0 = rdc_cnt; b0 = byte_cnt;
        do_cmd(); set_count(3);
        host_write(2'd2, 32'hdead_beef);
        frame_done(r0, b0, 3, "R7 surplus");

        // R5: pointer reset drops earlier bytes
        rdy_mode = 0;
        r0 = rdc_cnt; b0 = byte_cnt;
        do_cmd(); set_count(4);
        host_write(2'd0, 32'h77);
        host_write(2'd0, 32'h66);
        do_cmd();
        for (int i = 0; i < 4; i++) host_write(2'd0, 32'h50 + i);
        frame_done(r0, b0, 4, "R5 cmd reset");

        // R10, R8: loaded address and byte reads
        load_addr(16'h1234);
        host_read(2'd0, "R10 R8 byte read at loaded address");
        host_read(2'd0, "R8 byte read increments");
        host_read(2'd0, "R8 byte read increments again");

        // R9: wide reads
        host_read(2'd1, "R9 half read");
        host_read(2'd2, "R9 word read");
        load_addr(16'hfffe);
        host_read(2'd2, "R9 word read across wrap");

        // R6: read request ignored while a frame is stalled
        rdy_mode = 3;
        r0 = rdc_cnt; b0 = byte_cnt;
        do_cmd(); set_count(2);
        issue(1'b1, 2'd1, 32'h0000_3c5a);
        model_write(2'd1, 32'h0000_3c5a);
        while (!tx_valid) @(negedge clk);
        hp_req = 1'b1; hp_write = 1'b0; hp_size = 2'd0;
        @(negedge clk);
        hp_req = 1'b0;
        for (int i = 0; i < 6; i++) begin
            chk(!pm_rd && !hp_rvalid && hp_busy, "R6 no fetch while busy", {pm_rd, hp_rvalid, hp_busy}, 32'd1);
            @(negedge clk);
        end
        rdy_mode = 0;
        while (hp_busy) @(negedge clk);
        @(negedge clk);
        frame_done(r0, b0, 2, "R6 stalled frame");
        host_read(2'd0, "R6 address unchanged by ignored read");

        // R11: zero count never starts
        r0 = rdc_cnt; b0 = byte_cnt;
        do_cmd(); set_count(0);
        host_write(2'd2, 32'h0102_0304);
        chk(rdc_cnt == r0 && byte_cnt == b0, "R11 zero count", 32'(rdc_cnt - r0), 32'd0);

        // R11: count equal to capacity
        rdy_mode = 2;
        r0 = rdc_cnt; b0 = byte_cnt;
        do_cmd(); set_count(DEPTH);
        for (int i = 0; i < DEPTH / 4; i++) host_write(2'd2, 32'(i * 32'h0101_0101 + 32'h0302_0100));
        frame_done(r0, b0, DEPTH, "R11 full capacity");

        // R11: count beyond capacity
        rdy_mode = 0;
        r0 = rdc_cnt; b0 = byte_cnt;
        do_cmd(); set_count(DEPTH + 1);
        for (int i = 0; i < DEPTH / 4 + 1; i++) host_write(2'd2, 32'(i));
        repeat (5) @(negedge clk);
        chk(rdc_cnt == r0 && byte_cnt == b0 && !tx_valid, "R11 overflow no frame",
            32'(rdc_cnt - r0), 32'd0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule